// File: doc/BRIEF.md
# Load Hit/Miss Speculation Filter

This block decides, for every load leaving the issue stage, whether its dependents may be woken on the assumption that the load will hit in the first-level data cache. If they are woken too early, a miss forces a replay. If they are held back, the load-to-use path grows by the whole issue-to-execute distance. The filter combines two sources of evidence. The first is a small global counter that tracks how often misses have occurred recently. The second is a direct-mapped table of per-load confidence counters, indexed by the load's program counter.

A table entry whose counter sits at either extreme gives a confident answer: always hit, or always miss. Once a load's behaviour leaves an extreme, its entry is muted and takes no further part in the decision. The global counter then decides for that load. Muted flags are released in bulk after a fixed number of committed loads. The table is trained only at commit time, so training stays off the issue path. A lookup reads the table state that was present before any update made in the same cycle.

Top module: `hmf_filter`

## Requirements
- R1: A global confidence counter of GCTR_W bits (default 4) resets to its maximum value (15). Whenever the table defers the decision, `spec_ok` equals the counter's top bit (value 8 or more).
- R2: In each cycle with `l1_miss` high, the global counter decreases by 2, saturating at 0. In every other cycle it increases by 1, saturating at its maximum.
- R3: The table has 2^IDX_W entries (default 2048), selected by the low IDX_W bits of the PC. Pins with PCs that differ only above those bits share an entry. At reset, every entry holds 2-bit value 2 (weakly hit) and is unmuted.
- R4: A commit (`cm_valid`) to an unmuted entry increments its 2-bit counter on `cm_hit`=1 and decrements it on `cm_hit`=0. The counter saturates at 3 and at 0.
- R5: An update that moves the counter from 3 to 2, or from 0 to 1, mutes the entry. A muted entry ignores later commits, and lookups that hit it use the global counter.
- R6: An unmuted entry at 3 gives `spec_ok`=1 and `sure_hit`=1. An unmuted entry at 0 gives `spec_ok`=0 regardless of the global counter. In every other case `sure_hit`=0.
- R7: The commit that completes each group of CLR_PERIOD commits (default 10000) has its own update applied. At that same clock edge, all mute flags are cleared.
- R8: When a lookup and a commit address the same entry in one cycle, the lookup's decision reflects the entry before that commit.
- R9: With `lk_valid` low, both `spec_ok` and `sure_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | A load is issuing this cycle |
| lk_pc | input | PC_W | PC of the issuing load |
| l1_miss | input | 1 | At least one L1 data miss occurred this cycle |
| cm_valid | input | 1 | A load commits this cycle |
| cm_pc | input | PC_W | PC of the committing load |
| cm_hit | input | 1 | Outcome of the committing load: 1 hit, 0 miss |
| spec_ok | output | 1 | Dependents may be woken speculatively |
| sure_hit | output | 1 | The table is confident the load hits |

## Verification
The bench first sweeps lookups over fresh entries. It then drives bursts of misses followed by quiet stretches, which separates the global counter's fall of 2 from its rise of 1 and checks both saturation points. Next, it trains individual PCs to the hit extreme and to the miss extreme while the global counter points the other way, which shows whether the table or the counter decides. It then knocks trained entries out of saturation and shows that they mute, and it also drives aliased PCs. Finally, it runs a long random phase with colliding lookup and commit indices and with commits passing the clear boundary, which exposes ordering errors in same-cycle updates and in the bulk release of mute flags.

// File: rtl/hmf_pkg.sv
package hmf_pkg;

    typedef enum logic [1:0] {
        CONF_MISS   = 2'd0,
        CONF_WMISS  = 2'd1,
        CONF_WHIT   = 2'd2,
        CONF_HIT    = 2'd3
    } conf_e;

    typedef enum logic [1:0] {
        SRC_TABLE_HIT,
        SRC_TABLE_MISS,
        SRC_GLOBAL
    } src_e;

    typedef struct packed {
        logic  muted;
        conf_e conf;
    } entry_t;

    function automatic conf_e conf_step(conf_e c, logic hit);
        conf_e r;
        if (hit) r = (c == CONF_HIT)  ? CONF_HIT  : conf_e'(c + 2'd1);
        else     r = (c == CONF_MISS) ? CONF_MISS : conf_e'(c - 2'd1);
        return r;
    endfunction

    function automatic logic conf_extreme(conf_e c);
        return (c == CONF_HIT) || (c == CONF_MISS);
    endfunction

endpackage

// File: rtl/hmf_gctr.sv
module hmf_gctr #(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic l1_miss,
    output logic confident
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= MAXV;
        else if (l1_miss) cnt_q <= (cnt_q < W'(2)) ? '0 : cnt_q - W'(2);
        else if (cnt_q != MAXV) cnt_q <= cnt_q + W'(1);
    end

    assign confident = cnt_q[W-1];

    // R2: a miss cycle never raises the counter, a quiet cycle never lowers it
    p_miss_no_rise_r2: assert property (@(posedge clk) disable iff (rst)
        l1_miss |=> cnt_q <= $past(cnt_q));
    p_quiet_no_fall_r2: assert property (@(posedge clk) disable iff (rst)
        !l1_miss |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/hmf_epoch.sv
module hmf_epoch #(
    parameter int PERIOD = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic cm_valid,
    output logic clr
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign clr = cm_valid && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)           cnt_q <= '0;
        else if (clr)      cnt_q <= '0;
        else if (cm_valid) cnt_q <= cnt_q + CW'(1);
    end

    // R7: the commit counter stays inside one period
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
endmodule

// File: rtl/hmf_table.sv
module hmf_table
    import hmf_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    output entry_t           lk_ent,
    input  logic             cm_valid,
    input  logic [IDX_W-1:0] cm_idx,
    input  logic             cm_hit,
    input  logic             clr
);
    localparam int DEPTH = 1 << IDX_W;

    conf_e            conf_q [DEPTH];
    logic [DEPTH-1:0] mute_q;

    conf_e cm_old, cm_new;
    logic  cm_live;

    assign lk_ent  = '{muted: mute_q[lk_idx], conf: conf_q[lk_idx]};
    assign cm_old  = conf_q[cm_idx];
    assign cm_new  = conf_step(cm_old, cm_hit);
    assign cm_live = cm_valid && !mute_q[cm_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) conf_q[i] <= CONF_WHIT;
            mute_q <= '0;
        end else begin
            if (cm_live) begin
                conf_q[cm_idx] <= cm_new;
                if (conf_extreme(cm_old) && !conf_extreme(cm_new))
                    mute_q[cm_idx] <= 1'b1;
            end
            if (clr) mute_q <= '0;
        end
    end

    // R5: a muted entry keeps its counter through a commit
    p_muted_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (cm_valid && mute_q[cm_idx]) |=> conf_q[$past(cm_idx)] == $past(cm_old));
    // R7: the bulk release leaves no entry muted
    p_clear_all_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> mute_q == '0);
    // R4: a live commit moves the counter by at most one step
    p_one_step_r4: assert property (@(posedge clk) disable iff (rst)
        cm_live |=> (conf_q[$past(cm_idx)] == $past(cm_new)));
endmodule

// File: rtl/hmf_filter.sv
module hmf_filter
    import hmf_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int IDX_W      = 11,
    parameter int GCTR_W     = 4,
    parameter int CLR_PERIOD = 10000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            l1_miss,
    input  logic            cm_valid,
    input  logic [PC_W-1:0] cm_pc,
    input  logic            cm_hit,
    output logic            spec_ok,
    output logic            sure_hit
);
    logic   g_conf;
    logic   clr;
    entry_t ent;
    src_e   src;

    hmf_gctr #(.W(GCTR_W)) u_gctr (
        .clk(clk), .rst(rst), .l1_miss(l1_miss), .confident(g_conf)
    );

    hmf_epoch #(.PERIOD(CLR_PERIOD)) u_epoch (
        .clk(clk), .rst(rst), .cm_valid(cm_valid), .clr(clr)
    );

    hmf_table #(.IDX_W(IDX_W)) u_table (
        .clk(clk), .rst(rst),
        .lk_idx(lk_pc[IDX_W-1:0]), .lk_ent(ent),
        .cm_valid(cm_valid), .cm_idx(cm_pc[IDX_W-1:0]), .cm_hit(cm_hit),
        .clr(clr)
    );

    always_comb begin
        if (!ent.muted && ent.conf == CONF_HIT)       src = SRC_TABLE_HIT;
        else if (!ent.muted && ent.conf == CONF_MISS) src = SRC_TABLE_MISS;
        else                                          src = SRC_GLOBAL;
    end

    always_comb begin
        spec_ok  = 1'b0;
        sure_hit = 1'b0;
        if (lk_valid) begin
            unique case (src)
                SRC_TABLE_HIT:  begin spec_ok = 1'b1; sure_hit = 1'b1; end
                SRC_TABLE_MISS: spec_ok = 1'b0;
                default:        spec_ok = g_conf;
            endcase
        end
    end

    // R6: a confident hit always allows speculation
    p_sure_implies_spec_r6: assert property (@(posedge clk) disable iff (rst)
        sure_hit |-> spec_ok);
    // R9: no decision without an issuing load
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !spec_ok && !sure_hit);
endmodule

// File: tb/tb_hmf_filter.sv
module tb_hmf_filter;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 32;
    localparam int NENT = 2048;
    localparam int CLRP = 10000;

    logic clk = 0, rst = 1;
    logic lk_valid = 0, l1_miss = 0, cm_valid = 0, cm_hit = 0;
    logic [PC_W-1:0] lk_pc = '0, cm_pc = '0;
    logic spec_ok, sure_hit;

    hmf_filter dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
        .l1_miss(l1_miss), .cm_valid(cm_valid), .cm_pc(cm_pc),
        .cm_hit(cm_hit), .spec_ok(spec_ok), .sure_hit(sure_hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;

    int ref_conf [NENT];
    bit ref_mute [NENT];
    int ref_g;
    int ref_commits;

    task automatic ref_reset();
        for (int i = 0; i < NENT; i++) begin ref_conf[i] = 2; ref_mute[i] = 0; end
        ref_g = 15;
        ref_commits = 0;
    endtask

    task automatic check(string tag, logic act_s, logic act_h, logic exp_s, logic exp_h);
        checks++;
        if (act_s !== exp_s || act_h !== exp_h) begin
            errors++;
            $display("FAIL %s: spec_ok/sure_hit actual %b/%b expected %b/%b",
                     tag, act_s, act_h, exp_s, exp_h);
        end
    endtask

    task automatic step(string phase, bit lv, int lpc, bit miss, bit cv, int cpc, bit ch);
        int li, ci;
        bit es, eh;
        string tag;
        @(negedge clk);
        lk_valid = lv; lk_pc = lpc; l1_miss = miss;
        cm_valid = cv; cm_pc = cpc; cm_hit = ch;
        #1;
        li = lpc % NENT;
        ci = cpc % NENT;
        if (!lv) begin es = 0; eh = 0; tag = "R9"; end
        else if (!ref_mute[li] && ref_conf[li] == 3) begin es = 1; eh = 1; tag = "R6"; end
        else if (!ref_mute[li] && ref_conf[li] == 0) begin es = 0; eh = 0; tag = "R6"; end
        else begin es = (ref_g >= 8); eh = 0; tag = ref_mute[li] ? "R5" : "R1"; end
        if (lv && cv && li == ci) tag = {tag, "+R8"};
        check({phase, "/", tag}, spec_ok, sure_hit, es, eh);
        @(posedge clk);
        // reference update for this edge
        if (miss) ref_g = (ref_g < 2) ? 0 : ref_g - 2;
        else if (ref_g < 15) ref_g++;
        if (cv) begin
            if (!ref_mute[ci]) begin
                int o, n;
                o = ref_conf[ci];
                n = ch ? ((o == 3) ? 3 : o + 1) : ((o == 0) ? 0 : o - 1);
                ref_conf[ci] = n;
                if ((o == 0 || o == 3) && (n == 1 || n == 2)) ref_mute[ci] = 1;
            end
            ref_commits++;
            if (ref_commits == CLRP) begin
                ref_commits = 0;
                for (int i = 0; i < NENT; i++) ref_mute[i] = 0;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        ref_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R3: fresh entries are weakly hit, global counter full
        for (int i = 0; i < 8; i++) step("R3", 1, i * 97, 0, 0, 0, 0);
        step("R9", 0, 5, 0, 0, 0, 0);

        // R2: miss bursts drive the global counter to 0, then recovery
        for (int i = 0; i < 10; i++) step("R2", 1, 300, 1, 0, 0, 0);
        for (int i = 0; i < 10; i++) step("R2", 1, 300, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) step("R2", 1, 300, i[0], 0, 0, 0);

        // R4: train 0x40 to hit extreme, 0x80 to miss extreme
        step("R4", 1, 'h40, 0, 1, 'h40, 1);
        step("R4", 1, 'h40, 0, 1, 'h40, 1);
        for (int i = 0; i < 10; i++) step("R4", 1, 'h40, 1, 0, 0, 0);
        for (int i = 0; i < 3; i++) step("R4", 1, 'h80, 0, 1, 'h80, 0);
        for (int i = 0; i < 16; i++) step("R4", 1, 'h80, 0, 0, 0, 0);
        step("R3", 1, 'h80 + NENT, 0, 0, 0, 0);

        // R5: leaving saturation mutes; later commits ignored; alias shares entry
        step("R5", 1, 'h40, 0, 1, 'h40, 0);
        step("R5", 1, 'h40, 0, 1, 'h40 + NENT, 1);
        step("R5", 1, 'h40, 0, 1, 'h40, 1);
        for (int i = 0; i < 10; i++) step("R5", 1, 'h40 + NENT, 1, 0, 0, 0);
        step("R5", 1, 'h80, 0, 1, 'h80, 1);
        for (int i = 0; i < 4; i++) step("R5", 1, 'h80, 0, 1, 'h80, 0);

        // R8: same-cycle lookup and commit on one entry
        step("R8", 1, 'h100, 0, 1, 'h100, 1);
        step("R8", 1, 'h100, 0, 1, 'h100, 1);
        step("R8", 1, 'h100, 0, 1, 'h100, 0);
        step("R8", 1, 'h100, 0, 0, 0, 0);

        // random mix over a small aliased PC set
        for (int i = 0; i < 3000; i++) begin
            int a, b;
            a = ($urandom % 6) * 64 + (($urandom % 2) * NENT);
            b = ($urandom % 6) * 64 + (($urandom % 2) * NENT);
            step("R4", $urandom % 4 != 0, a, $urandom % 3 == 0,
                 $urandom % 2, b, $urandom % 4 != 0);
        end

        // R7: run commits across the clear boundary
        while (ref_commits < CLRP - 20) step("R7", 0, 0, 0, 1, 'h200 + ($urandom % 4), 1);
        for (int i = 0; i < 60; i++) begin
            int a;
            a = ($urandom % 6) * 64;
            step("R7", 1, a, $urandom % 4 == 0, 1, a, $urandom % 3 != 0);
        end
        for (int i = 0; i < 6; i++) step("R7", 1, i * 64, 0, 0, 0, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule